// File: doc/BRIEF.md
# Memory Operation Ordering Tracker

This block follows every memory operation between dispatch and its executed event. It keeps one queue of pending loads and one of pending stores. Each operation carries an age tag that grows by one per operation and wraps around. A scheduler uses the block in three ways. Before dispatch it asks whether the queues have room for an operation. At dispatch it records the operation. While the operation waits, it asks whether the operation may issue, and if not, which older operation holds it back.

Readiness follows fixed ordering rules. Loads may pass older loads. Stores pass nothing older. Loads pass older stores only when the no-alias configuration bit is set. An operation with side effects acts as a barrier. Younger operations of the same kind wait behind it, and it waits until it is the oldest entry of its own queue. The executed event frees the queue entries. A barrier record is cleared only when the executed operation is the oldest barrier of its kind.

Top module: `mem_order_tracker`

## Requirements
- R1: `chk_status` encodes 0 = room available, 1 = load queue full, 2 = store queue full. The load queue is tested first, so an operation that both loads and stores reports 1 when both queues are full. An operation that neither loads nor stores always reports 0.
- R2: A queue with a nonzero size parameter N is full when it holds N entries. A size of 0 means no configured limit, so that queue reports full only when it holds DEPTH entries.
- R3: An operation that both loads and stores takes one entry in each queue. Its executed event frees both entries.
- R4: A load with side effects becomes a load barrier, and a store with side effects becomes a store barrier. A younger load (or store) is not ready while the oldest load (or store) barrier is pending, and that barrier's tag is reported as the blocker.
- R5: A barrier is not ready until it is the oldest entry of its own queue. Until then, the oldest entry of that queue is the blocker.
- R6: With `no_alias` = 1, a load that clears the barrier rules is ready even when older stores are pending.
- R7: With `no_alias` = 0, any load or store younger than the oldest pending store is blocked by that store. Stores obey this rule whatever the value of `no_alias`.
- R8: After the store rule, a load is ready regardless of older loads. A store younger than the oldest pending load is blocked by that load.
- R9: An executed event removes the tag from both queues. A barrier record is dropped only if the tag equals the oldest barrier of that kind. A younger barrier executed out of turn therefore keeps blocking.
- R10: A dispatch while its own status is not 0, or an executed event whose tag is in neither queue, sets `err` and leaves the queue state unchanged. `err` stays set until reset.
- R11: Ages are compared modulo 2^TAG_W: tag a is older than tag b when bit TAG_W-1 of (a - b) is 1, so ordering holds across the wrap from the highest tag to 0.
- R12: The query outputs depend combinationally on the query inputs and the registered state. When ready, `qry_blocker` equals `qry_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| no_alias | input | 1 | Loads are assumed never to overlap stores |
| chk_load | input | 1 | Operation being checked reads memory |
| chk_store | input | 1 | Operation being checked writes memory |
| chk_status | output | 2 | Room status for the checked operation |
| disp_valid | input | 1 | Dispatch an operation this cycle |
| disp_load | input | 1 | Dispatched operation reads memory |
| disp_store | input | 1 | Dispatched operation writes memory |
| disp_side | input | 1 | Dispatched operation has side effects |
| disp_tag | input | TAG_W | Age tag of the dispatched operation |
| exec_valid | input | 1 | An operation finished execution |
| exec_tag | input | TAG_W | Tag of the executed operation |
| qry_load | input | 1 | Queried operation reads memory |
| qry_store | input | 1 | Queried operation writes memory |
| qry_tag | input | TAG_W | Tag of the queried operation |
| qry_ready | output | 1 | Queried operation may issue |
| qry_blocker | output | TAG_W | Queried tag when ready, otherwise the blocking tag |
| err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with TAG_W = 4, DEPTH = 4, an unlimited load queue and a two-entry store queue. A four-bit tag lets a handful of operations cross the wrap from 15 to 0, which exercises the modular age compare. The unlimited load queue shows the physical depth acting as the ceiling. The two-entry store queue fills after two stores, so a rejected dispatch and its lack of effect can be observed through `chk_status`.

// File: rtl/mot_pkg.sv
package mot_pkg;

  typedef enum logic [1:0] {
    AVL_OK      = 2'd0,
    AVL_LQ_FULL = 2'd1,
    AVL_SQ_FULL = 2'd2
  } avail_e;

  // Tag sets kept by the tracker
  localparam int NUM_SETS = 4;
  localparam int SET_LQ   = 0;
  localparam int SET_SQ   = 1;
  localparam int SET_LB   = 2;
  localparam int SET_SB   = 3;

endpackage

// File: rtl/lsot_age_set.sv
module lsot_age_set #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 8,
  parameter int CAP   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             rem_en,
  input  logic [TAG_W-1:0] rem_tag,
  output logic             hit,
  output logic             full,
  output logic             empty,
  output logic [TAG_W-1:0] oldest
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tags [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;
  logic             found;

  function automatic logic is_older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[TAG_W-1];
  endfunction

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    end
  end

  always_comb begin
    hit = 1'b0;
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt = cnt + CNT_W'(vld[i]);
      if (vld[i] && tags[i] == rem_tag) hit = 1'b1;
    end
  end

  always_comb begin
    found  = 1'b0;
    oldest = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && (!found || is_older(tags[i], oldest))) begin
        oldest = tags[i];
        found  = 1'b1;
      end
    end
  end

  assign empty = ~|vld;
  assign full  = (cnt == CNT_W'(CAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rem_en && vld[i] && tags[i] == rem_tag) vld[i] <= 1'b0;
      end
      if (ins_en && have_free) vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en && have_free) tags[free_idx] <= ins_tag;
  end

endmodule

// File: rtl/lsot_ready_rules.sv
module lsot_ready_rules #(
  parameter int TAG_W = 6
) (
  input  logic             no_alias,
  input  logic             q_load,
  input  logic             q_store,
  input  logic [TAG_W-1:0] q_tag,
  input  logic             lq_empty,
  input  logic [TAG_W-1:0] lq_oldest,
  input  logic             sq_empty,
  input  logic [TAG_W-1:0] sq_oldest,
  input  logic             lb_empty,
  input  logic [TAG_W-1:0] lb_oldest,
  input  logic             sb_empty,
  input  logic [TAG_W-1:0] sb_oldest,
  output logic             ready,
  output logic [TAG_W-1:0] blocker
);

  logic decided;

  function automatic logic is_older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[TAG_W-1];
  endfunction

  always_comb begin
    ready   = 1'b1;
    blocker = q_tag;
    decided = 1'b0;
    // load barrier rules
    if (q_load && !lb_empty) begin
      if (is_older(lb_oldest, q_tag)) begin
        ready = 1'b0; blocker = lb_oldest; decided = 1'b1;
      end else if (q_tag == lb_oldest && !lq_empty && lq_oldest != q_tag) begin
        ready = 1'b0; blocker = lq_oldest; decided = 1'b1;
      end
    end
    // store barrier rules
    if (!decided && q_store && !sb_empty) begin
      if (is_older(sb_oldest, q_tag)) begin
        ready = 1'b0; blocker = sb_oldest; decided = 1'b1;
      end else if (q_tag == sb_oldest && !sq_empty && sq_oldest != q_tag) begin
        ready = 1'b0; blocker = sq_oldest; decided = 1'b1;
      end
    end
    // loads skip stores when aliasing is ruled out
    if (!decided && q_load && no_alias) decided = 1'b1;
    // nothing passes an older store
    if (!decided && !sq_empty && is_older(sq_oldest, q_tag)) begin
      ready = 1'b0; blocker = sq_oldest; decided = 1'b1;
    end
    // stores do not pass older loads; loads do
    if (!decided && !q_load && !lq_empty && is_older(lq_oldest, q_tag)) begin
      ready = 1'b0; blocker = lq_oldest;
    end
  end

endmodule

// File: rtl/mem_order_tracker.sv
module mem_order_tracker
  import mot_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int DEPTH   = 8,
  parameter int LQ_SIZE = 6,
  parameter int SQ_SIZE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             no_alias,
  input  logic             chk_load,
  input  logic             chk_store,
  output logic [1:0]       chk_status,
  input  logic             disp_valid,
  input  logic             disp_load,
  input  logic             disp_store,
  input  logic             disp_side,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic             exec_valid,
  input  logic [TAG_W-1:0] exec_tag,
  input  logic             qry_load,
  input  logic             qry_store,
  input  logic [TAG_W-1:0] qry_tag,
  output logic             qry_ready,
  output logic [TAG_W-1:0] qry_blocker,
  output logic             err
);

  localparam int LQ_CAP = (LQ_SIZE == 0 || LQ_SIZE > DEPTH) ? DEPTH : LQ_SIZE;
  localparam int SQ_CAP = (SQ_SIZE == 0 || SQ_SIZE > DEPTH) ? DEPTH : SQ_SIZE;

  logic [NUM_SETS-1:0] s_ins, s_rem, s_hit, s_full, s_empty;
  logic [TAG_W-1:0]    s_old [NUM_SETS];
  avail_e              disp_stat;
  logic                disp_ok, exec_hit, exec_ok;
  logic                err_q;
  logic                unused_bar;

  function automatic avail_e room(input logic ld, input logic st, input logic lq_full, input logic sq_full);
    if (ld && lq_full)      return AVL_LQ_FULL;
    else if (st && sq_full) return AVL_SQ_FULL;
    else                    return AVL_OK;
  endfunction

  assign chk_status = room(chk_load, chk_store, s_full[SET_LQ], s_full[SET_SQ]);
  assign disp_stat  = room(disp_load, disp_store, s_full[SET_LQ], s_full[SET_SQ]);
  assign disp_ok    = disp_valid && (disp_stat == AVL_OK);
  assign exec_hit   = s_hit[SET_LQ] | s_hit[SET_SQ];
  assign exec_ok    = exec_valid && exec_hit;

  assign s_ins[SET_LQ] = disp_ok && disp_load;
  assign s_ins[SET_SQ] = disp_ok && disp_store;
  assign s_ins[SET_LB] = disp_ok && disp_load && disp_side;
  assign s_ins[SET_SB] = disp_ok && disp_store && disp_side;

  assign s_rem[SET_LQ] = exec_ok;
  assign s_rem[SET_SQ] = exec_ok;
  assign s_rem[SET_LB] = exec_ok && !s_empty[SET_LB] && (exec_tag == s_old[SET_LB]);
  assign s_rem[SET_SB] = exec_ok && !s_empty[SET_SB] && (exec_tag == s_old[SET_SB]);

  assign unused_bar = ^{s_hit[SET_SB:SET_LB], s_full[SET_SB:SET_LB]};

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    localparam int SET_CAP = (g == SET_LQ) ? LQ_CAP : (g == SET_SQ) ? SQ_CAP : DEPTH;
    lsot_age_set #(
      .TAG_W (TAG_W),
      .DEPTH (DEPTH),
      .CAP   (SET_CAP)
    ) u_set (
      .clk     (clk),
      .rst     (rst),
      .ins_en  (s_ins[g]),
      .ins_tag (disp_tag),
      .rem_en  (s_rem[g]),
      .rem_tag (exec_tag),
      .hit     (s_hit[g]),
      .full    (s_full[g]),
      .empty   (s_empty[g]),
      .oldest  (s_old[g])
    );
  end

  lsot_ready_rules #(.TAG_W(TAG_W)) u_rules (
    .no_alias  (no_alias),
    .q_load    (qry_load),
    .q_store   (qry_store),
    .q_tag     (qry_tag),
    .lq_empty  (s_empty[SET_LQ]),
    .lq_oldest (s_old[SET_LQ]),
    .sq_empty  (s_empty[SET_SQ]),
    .sq_oldest (s_old[SET_SQ]),
    .lb_empty  (s_empty[SET_LB]),
    .lb_oldest (s_old[SET_LB]),
    .sb_empty  (s_empty[SET_SB]),
    .sb_oldest (s_old[SET_SB]),
    .ready     (qry_ready),
    .blocker   (qry_blocker)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if ((disp_valid && disp_stat != AVL_OK) || (exec_valid && !exec_hit)) begin
      err_q <= 1'b1;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/mem_order_tracker_chk.sv
module mem_order_tracker_chk #(
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             chk_load,
  input logic             chk_store,
  input logic [1:0]       chk_status,
  input logic             qry_load,
  input logic             qry_store,
  input logic [TAG_W-1:0] qry_tag,
  input logic             qry_ready,
  input logic [TAG_W-1:0] qry_blocker,
  input logic             err
);

  logic [TAG_W-1:0] blk_minus_q;
  assign blk_minus_q = qry_blocker - qry_tag;

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst) chk_status != 2'd3); // R1
  AST_NONMEM_AVAIL: assert property (@(posedge clk) disable iff (rst)
    (!chk_load && !chk_store) |-> chk_status == 2'd0); // R1
  AST_READY_ECHO: assert property (@(posedge clk) disable iff (rst)
    qry_ready |-> qry_blocker == qry_tag); // R12
  AST_BLOCKER_OLDER: assert property (@(posedge clk) disable iff (rst)
    ((qry_load || qry_store) && !qry_ready) |-> blk_minus_q[TAG_W-1]); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err |=> err); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) rst |=> !err); // R10

endmodule

bind mem_order_tracker mem_order_tracker_chk #(.TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chk_load    (chk_load),
  .chk_store   (chk_store),
  .chk_status  (chk_status),
  .qry_load    (qry_load),
  .qry_store   (qry_store),
  .qry_tag     (qry_tag),
  .qry_ready   (qry_ready),
  .qry_blocker (qry_blocker),
  .err         (err)
);

// File: tb/mem_order_tracker_bench.sv
`timescale 1ns/100ps
module mem_order_tracker_bench;

  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          no_alias = 1'b0;
  logic          chk_load = 1'b0, chk_store = 1'b0;
  logic [1:0]    chk_status;
  logic          disp_valid = 1'b0, disp_load = 1'b0, disp_store = 1'b0, disp_side = 1'b0;
  logic [TW-1:0] disp_tag = '0;
  logic          exec_valid = 1'b0;
  logic [TW-1:0] exec_tag = '0;
  logic          qry_load = 1'b0, qry_store = 1'b0;
  logic [TW-1:0] qry_tag = '0;
  logic          qry_ready;
  logic [TW-1:0] qry_blocker;
  logic          err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mem_order_tracker #(.TAG_W(TW), .DEPTH(4), .LQ_SIZE(0), .SQ_SIZE(2)) u_mem_order_tracker (
    .clk(clk), .rst(rst), .no_alias(no_alias),
    .chk_load(chk_load), .chk_store(chk_store), .chk_status(chk_status),
    .disp_valid(disp_valid), .disp_load(disp_load), .disp_store(disp_store),
    .disp_side(disp_side), .disp_tag(disp_tag),
    .exec_valid(exec_valid), .exec_tag(exec_tag),
    .qry_load(qry_load), .qry_store(qry_store), .qry_tag(qry_tag),
    .qry_ready(qry_ready), .qry_blocker(qry_blocker), .err(err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; no_alias = 1'b0;
    qry_load = 1'b0; qry_store = 1'b0; chk_load = 1'b0; chk_store = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic disp(input logic l, input logic s, input logic se, input int t);
    @(negedge clk);
    disp_valid = 1'b1; disp_load = l; disp_store = s; disp_side = se; disp_tag = TW'(t);
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic exe(input int t);
    @(negedge clk);
    exec_valid = 1'b1; exec_tag = TW'(t);
    @(negedge clk);
    exec_valid = 1'b0;
  endtask

  task automatic room(input string req, input logic l, input logic s, input int exp);
    chk_load = l; chk_store = s;
    #1;
    check(req, int'(chk_status), exp);
  endtask

  task automatic ask(input string req, input logic l, input logic s, input int t,
                     input logic exp_rdy, input int exp_blk);
    qry_load = l; qry_store = s; qry_tag = TW'(t);
    #1;
    check(req, int'(qry_ready), int'(exp_rdy));
    check(req, int'(qry_blocker), exp_blk);
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    check("R10 reset err", int'(err), 0);
    room("R1 empty load", 1, 0, 0);
    ask("R12 empty query", 1, 0, 3, 1'b1, 3);
  endtask

  task automatic t_capacity();
    do_reset();
    disp(0, 1, 0, 1);
    disp(0, 1, 0, 2);
    room("R2 store full at 2", 0, 1, 2);
    room("R1 load room", 1, 0, 0);
    disp(1, 0, 0, 3); disp(1, 0, 0, 4); disp(1, 0, 0, 5);
    room("R2 unlimited lq at 3", 1, 0, 0);
    disp(1, 0, 0, 6);
    room("R2 depth ceiling", 1, 0, 1);
    room("R1 load checked first", 1, 1, 1);
    room("R1 non-memory", 0, 0, 0);
    check("R10 no err yet", int'(err), 0);
    disp(0, 1, 0, 7);
    check("R10 rejected dispatch", int'(err), 1);
    exe(1);
    room("R10 rejected store not added", 0, 1, 0);
    check("R10 err sticky", int'(err), 1);
  endtask

  task automatic t_dual();
    do_reset();
    disp(1, 1, 0, 1);
    disp(0, 1, 0, 2);
    room("R3 dual op holds store entry", 0, 1, 2);
    ask("R7 store behind store", 0, 1, 2, 1'b0, 1);
    exe(1);
    room("R3 store entry freed", 0, 1, 0);
    ask("R3 load entry freed", 0, 1, 2, 1'b1, 2);
  endtask

  task automatic t_barriers();
    do_reset();
    disp(1, 0, 0, 1);
    disp(1, 0, 1, 2);
    disp(1, 0, 0, 3);
    ask("R4 load behind load barrier", 1, 0, 3, 1'b0, 2);
    ask("R5 barrier waits oldest load", 1, 0, 2, 1'b0, 1);
    ask("R8 oldest load ready", 1, 0, 1, 1'b1, 1);
    exe(1);
    ask("R5 barrier now oldest", 1, 0, 2, 1'b1, 2);
    ask("R4 still behind barrier", 1, 0, 3, 1'b0, 2);
    exe(2);
    ask("R4 barrier gone", 1, 0, 3, 1'b1, 3);
    exe(3);
    disp(0, 1, 0, 4);
    disp(0, 1, 1, 5);
    ask("R5 store barrier waits", 0, 1, 5, 1'b0, 4);
    ask("R7 oldest store ready", 0, 1, 4, 1'b1, 4);
    exe(4);
    disp(0, 1, 0, 6);
    ask("R4 store behind store barrier", 0, 1, 6, 1'b0, 5);
  endtask

  task automatic t_alias();
    do_reset();
    disp(0, 1, 0, 1);
    disp(1, 0, 0, 2);
    ask("R7 load behind store", 1, 0, 2, 1'b0, 1);
    no_alias = 1'b1;
    ask("R6 load skips store", 1, 0, 2, 1'b1, 2);
    disp(0, 1, 0, 3);
    ask("R7 store behind store with no_alias", 0, 1, 3, 1'b0, 1);
    exe(1);
    ask("R8 store behind older load", 0, 1, 3, 1'b0, 2);
    do_reset();
    disp(1, 0, 0, 1);
    disp(1, 0, 0, 2);
    ask("R8 load passes load", 1, 0, 2, 1'b1, 2);
  endtask

  task automatic t_stale_barrier();
    do_reset();
    disp(1, 0, 0, 1);
    disp(1, 0, 1, 2);
    disp(1, 0, 1, 3);
    exe(3);
    exe(2);
    disp(1, 0, 0, 4);
    ask("R9 younger barrier record persists", 1, 0, 4, 1'b0, 3);
    ask("R9 older load ready", 1, 0, 1, 1'b1, 1);
    check("R9 no error", int'(err), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    disp(0, 1, 0, 14);
    disp(1, 0, 0, 1);
    ask("R11 wrapped load behind store", 1, 0, 1, 1'b0, 14);
    disp(1, 0, 0, 15);
    ask("R11 load 15 behind store 14", 1, 0, 15, 1'b0, 14);
    ask("R11 store 14 older than loads", 0, 1, 14, 1'b1, 14);
  endtask

  task automatic t_bad_exec();
    do_reset();
    exe(9);
    check("R10 unknown tag", int'(err), 1);
    repeat (3) @(negedge clk);
    check("R10 err held", int'(err), 1);
    do_reset();
    #1;
    check("R10 err cleared by reset", int'(err), 0);
  endtask

  initial begin
    t_reset_state();
    t_capacity();
    t_dual();
    t_barriers();
    t_alias();
    t_stale_barrier();
    t_wrap();
    t_bad_exec();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule